// File: doc/BRIEF.md
# Context-Windowed Register File

This block is the general register file of a small processor core. One large physical array is split into equal windows, one per resident software context. A small context pointer register chooses which window the architectural register indices reach. The physical address is the pointer joined with the index. A context switch is therefore one pointer load. No register contents are saved to memory or restored from it, and every context keeps its values while it is not selected.

The core reaches the file through two combinational read ports and one write port, all addressed by architectural index. A pointer-load strobe carries the next context number. A supervisor port reads or writes any physical register by its flat address, so it can set up or inspect contexts that are not selected. Every architectural index is an ordinary operand: no index is hardwired and none is reserved. Writes land at the clock edge. A read that hits the same physical register as a write in the same cycle returns the data being written.

Top module: `ctx_regfile`

## Requirements
- R1: After reset the context pointer output is 0 and every physical register reads as 0.
- R2: A read port returns the register at physical address {context pointer (3 bits), index (5 bits)}, that is context*32 + index, for 8 contexts of 32 registers each (256 registers). A value written through the write port is read back at that address from the next cycle on.
- R3: A pointer load with a context number from 0 to 7 sets the pointer at the clock edge, so the new window is seen from the next cycle. Register contents of all windows are left unchanged.
- R4: A pointer load with a context number from 8 to 15 is ignored. The pointer keeps its value.
- R5: A register write issued in the same cycle as a pointer load goes into the window of the old pointer.
- R6: A read in the same cycle as a write to the same physical register returns the new write data (write-first bypass). This holds on both read ports and on the supervisor read.
- R7: The supervisor port reads the register at its 8-bit flat address combinationally and, when its write enable is high, writes that register at the clock edge. Any window can be reached this way, whatever the pointer value.
- R8: When the core write and a supervisor write hit the same physical register in one cycle, the core write wins. When they hit different registers, both are stored.
- R9: All 32 indices, 0 and 31 included, store and return written values. No index is hardwired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Read port A architectural index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 5 | Read port B architectural index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Core write enable |
| wr_idx_i | input | 5 | Core write architectural index |
| wr_data_i | input | 32 | Core write data |
| ctx_load_i | input | 1 | Context pointer load strobe |
| ctx_num_i | input | 4 | Requested context number |
| ctx_o | output | 3 | Current context pointer |
| sup_we_i | input | 1 | Supervisor write enable |
| sup_addr_i | input | 8 | Supervisor flat physical address |
| sup_wdata_i | input | 32 | Supervisor write data |
| sup_rdata_o | output | 32 | Supervisor read data |

## Verification
The bench writes in the same cycle as a pointer load and then reads the target through the supervisor port. A design that applied the new pointer too early would put the data in the wrong window. Pointer loads of 8 to 15 are checked, because a design that truncated the number would switch to a wrong context. Reads that hit the write address in the same cycle are checked, because a design without bypass would return stale data. Core and supervisor writes that collide on one register are checked, because a design with the wrong priority would keep the supervisor value. Random traffic runs against a bench model of all 256 registers and catches address translation that mixes up windows.

// File: rtl/ctx_regfile_pkg.sv
package ctx_regfile_pkg;
  localparam int unsigned DEF_NUM_CTX  = 8;
  localparam int unsigned DEF_WIN_REGS = 32;
  localparam int unsigned DEF_DATA_W   = 32;
endpackage

// File: rtl/ctx_ptr.sv
module ctx_ptr #(
  parameter int unsigned NUM_CTX  = 8,
  parameter int unsigned CTX_W    = 3,
  parameter int unsigned CTX_IN_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CTX_IN_W-1:0] num_i,
  output logic [CTX_W-1:0]    ctx_o
);
  logic in_range;
  assign in_range = ({1'b0, num_i} < (CTX_IN_W+1)'(NUM_CTX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctx_o <= '0;
    else if (load_i && in_range) ctx_o <= num_i[CTX_W-1:0];
  end
endmodule

// File: rtl/ctx_write_sel.sv
module ctx_write_sel #(
  parameter int unsigned PHYS_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              core_en_i,
  input  logic [PHYS_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic              sup_en_i,
  input  logic [PHYS_W-1:0] sup_addr_i,
  input  logic [DATA_W-1:0] sup_data_i,
  output logic              a_en_o,
  output logic [PHYS_W-1:0] a_addr_o,
  output logic [DATA_W-1:0] a_data_o,
  output logic              b_en_o,
  output logic [PHYS_W-1:0] b_addr_o,
  output logic [DATA_W-1:0] b_data_o
);
  // core write always lands; supervisor write drops on address collision
  assign a_en_o   = core_en_i;
  assign a_addr_o = core_addr_i;
  assign a_data_o = core_data_i;
  assign b_en_o   = sup_en_i && !(core_en_i && (core_addr_i == sup_addr_i));
  assign b_addr_o = sup_addr_i;
  assign b_data_o = sup_data_i;
endmodule

// File: rtl/ctx_rf_array.sv
module ctx_rf_array #(
  parameter int unsigned NUM_PHYS = 256,
  parameter int unsigned PHYS_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wa_en_i,
  input  logic [PHYS_W-1:0]              wa_addr_i,
  input  logic [DATA_W-1:0]              wa_data_i,
  input  logic                           wb_en_i,
  input  logic [PHYS_W-1:0]              wb_addr_i,
  input  logic [DATA_W-1:0]              wb_data_i,
  input  logic [NUM_RD-1:0][PHYS_W-1:0]  raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_PHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_PHYS); i++) mem_q[i] <= '0;
    end else begin
      if (wa_en_i) mem_q[wa_addr_i] <= wa_data_i;
      if (wb_en_i) mem_q[wb_addr_i] <= wb_data_i;
    end
  end

  for (genvar p = 0; p < int'(NUM_RD); p++) begin : g_rd
    always_comb begin
      if (wa_en_i && wa_addr_i == raddr_i[p])      rdata_o[p] = wa_data_i;
      else if (wb_en_i && wb_addr_i == raddr_i[p]) rdata_o[p] = wb_data_i;
      else                                         rdata_o[p] = mem_q[raddr_i[p]];
    end
  end
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
  import ctx_regfile_pkg::*;
#(
  parameter int unsigned NUM_CTX  = DEF_NUM_CTX,
  parameter int unsigned WIN_REGS = DEF_WIN_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned CTX_W    = $clog2(NUM_CTX),
  localparam int unsigned CTX_IN_W = CTX_W + 1,
  localparam int unsigned IDX_W    = $clog2(WIN_REGS),
  localparam int unsigned PHYS_W   = CTX_W + IDX_W,
  localparam int unsigned NUM_PHYS = NUM_CTX * WIN_REGS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    rd_a_idx_i,
  output logic [DATA_W-1:0]   rd_a_data_o,
  input  logic [IDX_W-1:0]    rd_b_idx_i,
  output logic [DATA_W-1:0]   rd_b_data_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                ctx_load_i,
  input  logic [CTX_IN_W-1:0] ctx_num_i,
  output logic [CTX_W-1:0]    ctx_o,
  input  logic                sup_we_i,
  input  logic [PHYS_W-1:0]   sup_addr_i,
  input  logic [DATA_W-1:0]   sup_wdata_i,
  output logic [DATA_W-1:0]   sup_rdata_o
);
  localparam int unsigned NUM_RD = 3;

  logic [CTX_W-1:0]              ctx_q;
  logic                          wa_en, wb_en;
  logic [PHYS_W-1:0]             wa_addr, wb_addr;
  logic [DATA_W-1:0]             wa_data, wb_data;
  logic [NUM_RD-1:0][PHYS_W-1:0] raddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rdata;

  ctx_ptr #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .CTX_IN_W(CTX_IN_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctx_load_i),
    .num_i  (ctx_num_i),
    .ctx_o  (ctx_q)
  );

  // core write translates with the pointer of this cycle (old one on a load)
  ctx_write_sel #(.PHYS_W(PHYS_W), .DATA_W(DATA_W)) u_wsel (
    .core_en_i   (wr_en_i),
    .core_addr_i ({ctx_q, wr_idx_i}),
    .core_data_i (wr_data_i),
    .sup_en_i    (sup_we_i),
    .sup_addr_i  (sup_addr_i),
    .sup_data_i  (sup_wdata_i),
    .a_en_o      (wa_en),
    .a_addr_o    (wa_addr),
    .a_data_o    (wa_data),
    .b_en_o      (wb_en),
    .b_addr_o    (wb_addr),
    .b_data_o    (wb_data)
  );

  assign raddr[0] = {ctx_q, rd_a_idx_i};
  assign raddr[1] = {ctx_q, rd_b_idx_i};
  assign raddr[2] = sup_addr_i;

  ctx_rf_array #(
    .NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wa_en_i   (wa_en),
    .wa_addr_i (wa_addr),
    .wa_data_i (wa_data),
    .wb_en_i   (wb_en),
    .wb_addr_i (wb_addr),
    .wb_data_i (wb_data),
    .raddr_i   (raddr),
    .rdata_o   (rdata)
  );

  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];
  assign sup_rdata_o = rdata[2];
  assign ctx_o       = ctx_q;
endmodule

// File: rtl/ctx_regfile_checker.sv
module ctx_regfile_checker #(
  parameter int unsigned CTX_W    = 3,
  parameter int unsigned CTX_IN_W = 4,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned PHYS_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CTX  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [IDX_W-1:0]    rd_a_idx_i,
  input logic [DATA_W-1:0]   rd_a_data_o,
  input logic [IDX_W-1:0]    rd_b_idx_i,
  input logic [DATA_W-1:0]   rd_b_data_o,
  input logic                wr_en_i,
  input logic [IDX_W-1:0]    wr_idx_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                ctx_load_i,
  input logic [CTX_IN_W-1:0] ctx_num_i,
  input logic [CTX_W-1:0]    ctx_o,
  input logic                sup_we_i,
  input logic [PHYS_W-1:0]   sup_addr_i,
  input logic [DATA_W-1:0]   sup_rdata_o
);
  logic load_ok;
  assign load_ok = ctx_load_i && ({1'b0, ctx_num_i} < (CTX_IN_W+1)'(NUM_CTX));

  a_r3_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> ctx_o == $past(ctx_num_i[CTX_W-1:0]));

  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ok |=> $stable(ctx_o));

  a_r6_bypass_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_a_idx_i == wr_idx_i) |-> rd_a_data_o == wr_data_i);

  a_r6_bypass_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_b_idx_i == wr_idx_i) |-> rd_b_data_o == wr_data_i);

  a_r8_core_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sup_we_i && sup_addr_i == {ctx_o, wr_idx_i}) |-> sup_rdata_o == wr_data_i);

  // R2 / R5: written value visible next cycle at the old pointer's window
  a_r2_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sup_we_i) |=>
      (wr_en_i || sup_we_i || ctx_o != $past(ctx_o) ||
       rd_a_idx_i != $past(wr_idx_i) || rd_a_data_o == $past(wr_data_i)));
endmodule

bind ctx_regfile ctx_regfile_checker #(
  .CTX_W(CTX_W), .CTX_IN_W(CTX_IN_W), .IDX_W(IDX_W),
  .PHYS_W(PHYS_W), .DATA_W(DATA_W), .NUM_CTX(NUM_CTX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_idx_i  (rd_a_idx_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_idx_i  (rd_b_idx_i),
  .rd_b_data_o (rd_b_data_o),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_data_i   (wr_data_i),
  .ctx_load_i  (ctx_load_i),
  .ctx_num_i   (ctx_num_i),
  .ctx_o       (ctx_o),
  .sup_we_i    (sup_we_i),
  .sup_addr_i  (sup_addr_i),
  .sup_rdata_o (sup_rdata_o)
);

// File: tb/ctx_regfile_test.sv
module ctx_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0, sup_wdata_i = '0, sup_rdata_o;
  logic        wr_en_i = 1'b0, ctx_load_i = 1'b0, sup_we_i = 1'b0;
  logic [3:0]  ctx_num_i = '0;
  logic [2:0]  ctx_o;
  logic [7:0]  sup_addr_i = '0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ref_mem [256];
  logic [2:0]  ref_ctx;

  always #4 clk_i = ~clk_i;

  ctx_regfile uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // expected read at a physical address given this cycle's writes
  function automatic logic [31:0] exp_rd(input logic [7:0] pa, input logic we, input logic [7:0] wpa,
                                         input logic [31:0] wd, input logic swe,
                                         input logic [7:0] spa, input logic [31:0] sd);
    if (we && wpa == pa)  return wd;
    if (swe && spa == pa) return sd;
    return ref_mem[pa];
  endfunction

  task automatic step(input logic [4:0] ra, input logic [4:0] rb, input logic we,
                      input logic [4:0] wi, input logic [31:0] wd, input logic ld,
                      input logic [3:0] ln, input logic swe, input logic [7:0] sa,
                      input logic [31:0] sd, input string tag);
    logic [7:0] wpa;
    @(negedge clk_i);
    rd_a_idx_i = ra; rd_b_idx_i = rb; wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    ctx_load_i = ld; ctx_num_i = ln; sup_we_i = swe; sup_addr_i = sa; sup_wdata_i = sd;
    #2;
    wpa = {ref_ctx, wi};
    chk({tag, " R3 ctx"}, 32'(ctx_o), 32'(ref_ctx));
    chk({tag, " rdA"}, rd_a_data_o, exp_rd({ref_ctx, ra}, we, wpa, wd, swe, sa, sd));
    chk({tag, " rdB"}, rd_b_data_o, exp_rd({ref_ctx, rb}, we, wpa, wd, swe, sa, sd));
    chk({tag, " R7 sup"}, sup_rdata_o, exp_rd(sa, we, wpa, wd, swe, sa, sd));
    if (swe && !(we && wpa == sa)) ref_mem[sa] = sd;
    if (we) ref_mem[wpa] = wd;
    if (ld && ln < 4'd8) ref_ctx = ln[2:0];
  endtask

  task automatic idle_rd(input logic [4:0] ra, input logic [7:0] sa, input string tag);
    step(ra, ra, 1'b0, 5'd0, 32'd0, 1'b0, 4'd0, 1'b0, sa, 32'd0, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    ref_ctx = '0;
    void'($urandom(32'd20240611));
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    for (int i = 0; i < 32; i++) begin
      idle_rd(5'(i), 8'(i * 8), "R1");
      chk("R1 zero", rd_a_data_o, 32'd0);
    end
    chk("R1 ctx", 32'(ctx_o), 32'd0);

    // R9: both end indices are ordinary registers
    step(5'd0, 5'd31, 1'b1, 5'd0, 32'h11, 1'b0, 4'd0, 1'b0, 8'd0, 32'd0, "R9");
    step(5'd0, 5'd31, 1'b1, 5'd31, 32'h22, 1'b0, 4'd0, 1'b0, 8'd0, 32'd0, "R9");
    idle_rd(5'd0, 8'd31, "R9");
    chk("R9 idx0", rd_a_data_o, 32'h11);
    chk("R9 idx31", sup_rdata_o, 32'h22);

    // R6: same-cycle bypass on read A
    step(5'd5, 5'd5, 1'b1, 5'd5, 32'h55, 1'b0, 4'd0, 1'b0, 8'd5, 32'd0, "R6");
    chk("R6 bypass", rd_a_data_o, 32'h55);

    // R5: write with load goes to old window
    step(5'd3, 5'd3, 1'b1, 5'd3, 32'hA3, 1'b1, 4'd5, 1'b0, 8'd0, 32'd0, "R5");
    idle_rd(5'd3, 8'd3, "R5");
    chk("R5 new window clean", rd_a_data_o, 32'd0);
    chk("R5 old window holds", sup_rdata_o, 32'hA3);
    chk("R3 switched", 32'(ctx_o), 32'd5);

    // R4: out-of-range load ignored
    step(5'd0, 5'd0, 1'b0, 5'd0, 32'd0, 1'b1, 4'd12, 1'b0, 8'd0, 32'd0, "R4");
    idle_rd(5'd0, 8'd0, "R4");
    chk("R4 ctx kept", 32'(ctx_o), 32'd5);

    // R3: switching back keeps contents
    step(5'd0, 5'd0, 1'b0, 5'd0, 32'd0, 1'b1, 4'd0, 1'b0, 8'd0, 32'd0, "R3");
    idle_rd(5'd0, 8'd0, "R3");
    chk("R3 contents kept", rd_a_data_o, 32'h11);

    // R8: collision, core wins; distinct addresses both land
    step(5'd7, 5'd7, 1'b1, 5'd7, 32'h77, 1'b0, 4'd0, 1'b1, 8'd7, 32'h99, "R8");
    idle_rd(5'd7, 8'd7, "R8");
    chk("R8 core wins", rd_a_data_o, 32'h77);
    step(5'd8, 5'd8, 1'b1, 5'd8, 32'h88, 1'b0, 4'd0, 1'b1, 8'd200, 32'hC8, "R8");
    idle_rd(5'd8, 8'd200, "R8");
    chk("R8 core kept", rd_a_data_o, 32'h88);
    chk("R8 sup kept", sup_rdata_o, 32'hC8);

    // R7: supervisor loads another window, core sees it after switch
    step(5'd0, 5'd0, 1'b0, 5'd0, 32'd0, 1'b0, 4'd0, 1'b1, 8'd196, 32'hC4, "R7");
    step(5'd0, 5'd0, 1'b0, 5'd0, 32'd0, 1'b1, 4'd6, 1'b0, 8'd0, 32'd0, "R7");
    idle_rd(5'd4, 8'd0, "R7");
    chk("R7 window6 idx4", rd_a_data_o, 32'hC4);

    // R2: random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ra, rb, wi;
      logic we, ld, swe;
      ra  = 5'($urandom);
      rb  = 5'($urandom);
      we  = ($urandom % 2) == 0;
      wi  = (($urandom % 4) == 0) ? ra : 5'($urandom);
      ld  = ($urandom % 8) == 0;
      swe = ($urandom % 6) == 0;
      step(ra, rb, we, wi, $urandom, ld, 4'($urandom),
           swe, (($urandom % 3) == 0) ? {ref_ctx, wi} : 8'($urandom), $urandom,
           (we && wi == ra) ? "R6 rnd" : "R2 rnd");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule